// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a 320x240 TFT panel fed through a parallel pixel port. From one bus clock it derives an active-low horizontal sync, an active-low vertical sync, a line-valid window that marks the bus ticks carrying pixel data, and a one-clock frame-start pulse. All intervals are counted in bus clock ticks. They scale with the number of bus ticks spent on each pixel, which is one, two or three depending on how wide the pixel port is compared with the pixel.

A two-bit mode select picks the ticks-per-pixel factor. It also picks a fixed latency correction that moves the first valid pixel later, to cover the pipeline that packs narrow bus words into pixels. The mode is captured only while the generator is stopped. Raising enable starts the horizontal and vertical counters together from the first tick of the first line. Dropping enable stops the counters and returns every output to its idle level.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset with enable low, hsyncN and vsyncN are 1 and lineValid and frameStart are 0.
- R2: Ticks within a line are numbered h = 0 .. H_TOTAL_PIX*cpp-1. hsyncN is 0 exactly while h < HSYNC_PIX*cpp, so the line period is H_TOTAL_PIX*cpp ticks. Here cpp is the ticks-per-pixel factor of the captured mode.
- R3: lineValid is 1 exactly when START_PIX*cpp+corr <= h < START_PIX*cpp+corr+ACT_PIX*cpp, and the line number v lies in BLANK_LINES/2 .. BLANK_LINES/2+ACT_LINES-1.
- R4: A frame has ACT_LINES+BLANK_LINES lines, numbered v = 0 upward. vsyncN is 0 exactly when v = 0 and h < VSYNC_PIX*cpp.
- R5: frameStart is 1 for one tick, in the tick where h = 0 and v = 0 while running.
- R6: Mode encoding of modeSel: 0 gives cpp=1 and corr=CORR_1X (0); 1 gives cpp=2 and corr=CORR_2X (3); 2 gives cpp=3 and corr=CORR_3X (5); 3 behaves exactly as 0.
- R7: modeSel is captured on every clock edge at which enable is low. Changes to modeSel while enable is high have no effect on any output until the next stop and restart.
- R8: The tick after the first clock edge that samples enable high has h = 0 and v = 0. The tick after any clock edge that samples enable low shows the idle levels of R1. Re-enabling always restarts at h = 0, v = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all timing is counted in its ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run when high; stop, clear and idle when low |
| modeSel | input | 2 | Ticks-per-pixel mode, captured while stopped |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| lineValid | output | 1 | High on ticks that carry active pixel data |
| frameStart | output | 1 | One-tick pulse at the first tick of each frame |

## Verification
The bench builds the generator with a shrunken raster: 6 active pixels in a 12-pixel line, a start offset of 2 pixels, and 5 active lines plus 4 blanking lines. The default latency corrections are kept. This shrinks a whole frame to at most 324 ticks. Every mode, including the reserved code, can then be compared tick by tick against arithmetic expectations over more than two full frames. That covers every line wrap, the frame wrap, the blanking lines on both sides of the active region, and the window edges shifted by each correction. It also covers a stop in mid-frame with an immediate restart, and a mode change applied while running.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  localparam int TIME_W = 16;

  typedef struct packed {
    logic [TIME_W-1:0] hPeriod;
    logic [TIME_W-1:0] hPulse;
    logic [TIME_W-1:0] hStart;
    logic [TIME_W-1:0] hEnd;
    logic [TIME_W-1:0] vPulse;
  } hcfg_t;

  typedef struct packed {
    logic clear;
    logic advance;
    logic active;
  } strobe_t;

  function automatic hcfg_t makeCfg(input int cpp, input int corr, input int actPix,
                                    input int totPix, input int hsPix, input int startPix,
                                    input int vsPix);
    hcfg_t c;
    c.hPeriod = TIME_W'(totPix * cpp);
    c.hPulse  = TIME_W'(hsPix * cpp);
    c.hStart  = TIME_W'(startPix * cpp + corr);
    c.hEnd    = TIME_W'(startPix * cpp + corr + actPix * cpp);
    c.vPulse  = TIME_W'(vsPix * cpp);
    return c;
  endfunction

endpackage

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int ACT_PIX     = 320,
  parameter int H_TOTAL_PIX = 336,
  parameter int HSYNC_PIX   = 2,
  parameter int START_PIX   = 7,
  parameter int VSYNC_PIX   = 2,
  parameter int CORR_1X     = 0,
  parameter int CORR_2X     = 3,
  parameter int CORR_3X     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] modeSel,
  output strobe_t    strobe,
  output hcfg_t      cfg
);

  localparam int NUM_MODES = 3;
  localparam int CORR_TAB [NUM_MODES] = '{CORR_1X, CORR_2X, CORR_3X};

  logic       runQ;
  logic [1:0] modeQ;
  hcfg_t      modeCfg [NUM_MODES];
  logic [1:0] modeIdx;

  for (genvar g = 0; g < NUM_MODES; g++) begin : gen_mode_cfg
    assign modeCfg[g] = makeCfg(g + 1, CORR_TAB[g], ACT_PIX, H_TOTAL_PIX,
                                HSYNC_PIX, START_PIX, VSYNC_PIX);
  end

  // Reserved code 3 falls back to the one-tick-per-pixel mode (R6)
  assign modeIdx = (modeQ == 2'd3) ? 2'd0 : modeQ;
  assign cfg     = modeCfg[modeIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      modeQ <= 2'd0;
    end else if (!enable) begin
      runQ  <= 1'b0;
      modeQ <= modeSel;
    end else begin
      runQ  <= 1'b1;
    end
  end

  assign strobe.clear   = !enable;
  assign strobe.advance = enable && runQ;
  assign strobe.active  = runQ;

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && enable) |=> $stable(modeQ));

  assert_stop_clears_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !runQ);

endmodule

// File: rtl/lcd_sync_datapath.sv
module lcd_sync_datapath
  import lcd_sync_pkg::*;
#(
  parameter int ACT_LINES   = 240,
  parameter int BLANK_LINES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  hcfg_t   cfg,
  output logic    hsyncN,
  output logic    vsyncN,
  output logic    lineValid,
  output logic    frameStart
);

  localparam int V_LINES = ACT_LINES + BLANK_LINES;
  localparam int V_W     = $clog2(V_LINES);
  localparam int V_FIRST = BLANK_LINES / 2;

  localparam logic [V_W-1:0] V_LAST     = V_W'(V_LINES - 1);
  localparam logic [V_W-1:0] V_ACT_LO   = V_W'(V_FIRST);
  localparam logic [V_W-1:0] V_ACT_HI   = V_W'(V_FIRST + ACT_LINES);

  logic [TIME_W-1:0] hCnt;
  logic [V_W-1:0]    vCnt;
  logic              hWrap;
  logic              vActive;
  logic              hActive;

  assign hWrap = (hCnt == cfg.hPeriod - TIME_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.advance) begin
      if (hWrap) begin
        hCnt <= '0;
        vCnt <= (vCnt == V_LAST) ? '0 : vCnt + V_W'(1);
      end else begin
        hCnt <= hCnt + TIME_W'(1);
      end
    end
  end

  assign vActive = (vCnt >= V_ACT_LO) && (vCnt < V_ACT_HI);
  assign hActive = (hCnt >= cfg.hStart) && (hCnt < cfg.hEnd);

  assign hsyncN     = !(strobe.active && (hCnt < cfg.hPulse));
  assign vsyncN     = !(strobe.active && (vCnt == '0) && (hCnt < cfg.vPulse));
  assign lineValid  = strobe.active && hActive && vActive;
  assign frameStart = strobe.active && (hCnt == '0) && (vCnt == '0);

  assert_hcnt_in_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active |-> (hCnt < cfg.hPeriod));

  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && hWrap && (vCnt == V_LAST)) |=> frameStart);

  assert_frame_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int ACT_PIX     = 320,
  parameter int H_TOTAL_PIX = 336,
  parameter int HSYNC_PIX   = 2,
  parameter int START_PIX   = 7,
  parameter int VSYNC_PIX   = 2,
  parameter int ACT_LINES   = 240,
  parameter int BLANK_LINES = 4,
  parameter int CORR_1X     = 0,
  parameter int CORR_2X     = 3,
  parameter int CORR_3X     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] modeSel,
  output logic       hsyncN,
  output logic       vsyncN,
  output logic       lineValid,
  output logic       frameStart
);

  strobe_t strobe;
  hcfg_t   cfg;

  lcd_sync_ctrl #(
    .ACT_PIX(ACT_PIX), .H_TOTAL_PIX(H_TOTAL_PIX), .HSYNC_PIX(HSYNC_PIX),
    .START_PIX(START_PIX), .VSYNC_PIX(VSYNC_PIX),
    .CORR_1X(CORR_1X), .CORR_2X(CORR_2X), .CORR_3X(CORR_3X)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .strobe(strobe), .cfg(cfg)
  );

  lcd_sync_datapath #(
    .ACT_LINES(ACT_LINES), .BLANK_LINES(BLANK_LINES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .lineValid(lineValid), .frameStart(frameStart)
  );

  assert_idle_after_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hsyncN && vsyncN && !lineValid && !frameStart));

  assert_window_outside_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> hsyncN);

  assert_vsync_inside_hsync_R4: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncN |-> !hsyncN);

  assert_frame_with_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!hsyncN && !vsyncN));

endmodule

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;

  localparam int ACT_PIX     = 6;
  localparam int H_TOTAL_PIX = 12;
  localparam int HSYNC_PIX   = 2;
  localparam int START_PIX   = 2;
  localparam int VSYNC_PIX   = 2;
  localparam int ACT_LINES   = 5;
  localparam int BLANK_LINES = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       hsyncN, vsyncN, lineValid, frameStart;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcd_sync_gen #(
    .ACT_PIX(ACT_PIX), .H_TOTAL_PIX(H_TOTAL_PIX), .HSYNC_PIX(HSYNC_PIX),
    .START_PIX(START_PIX), .VSYNC_PIX(VSYNC_PIX),
    .ACT_LINES(ACT_LINES), .BLANK_LINES(BLANK_LINES)
  ) i_lcd_sync_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .lineValid(lineValid), .frameStart(frameStart)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "hsyncN idle", hsyncN, 1);
    check(req, "vsyncN idle", vsyncN, 1);
    check(req, "lineValid idle", lineValid, 0);
    check(req, "frameStart idle", frameStart, 0);
  endtask

  // R6: mode code to ticks per pixel and correction
  function automatic int cppOf(input int m);
    return (m == 1) ? 2 : (m == 2) ? 3 : 1;
  endfunction
  function automatic int corrOf(input int m);
    return (m == 1) ? 3 : (m == 2) ? 5 : 0;
  endfunction

  task automatic checkTick(input int m, input int t);
    int cpp   = cppOf(m);
    int hP    = H_TOTAL_PIX * cpp;
    int h     = t % hP;
    int v     = (t / hP) % (ACT_LINES + BLANK_LINES);
    int st    = START_PIX * cpp + corrOf(m);
    int expHs = (h < HSYNC_PIX * cpp) ? 0 : 1;
    int expVs = (v == 0 && h < VSYNC_PIX * cpp) ? 0 : 1;
    int expLv = (v >= BLANK_LINES / 2 && v < BLANK_LINES / 2 + ACT_LINES &&
                 h >= st && h < st + ACT_PIX * cpp) ? 1 : 0;
    int expFs = (h == 0 && v == 0) ? 1 : 0;
    check("R2/R6", $sformatf("hsyncN mode %0d t %0d", m, t), hsyncN, expHs);
    check("R4/R6", $sformatf("vsyncN mode %0d t %0d", m, t), vsyncN, expVs);
    check("R3/R6", $sformatf("lineValid mode %0d t %0d", m, t), lineValid, expLv);
    check("R5", $sformatf("frameStart mode %0d t %0d", m, t), frameStart, expFs);
  endtask

  // Stop, capture mode m, run n ticks; optionally disturb modeSel at tick chgAt (R7)
  task automatic runMode(input int m, input int n, input int chgAt);
    @(negedge clk);
    enable  = 1'b0;
    modeSel = 2'(m);
    @(negedge clk);
    checkIdle("R8 stopped");
    enable = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (t == chgAt) modeSel = 2'(m ^ 2);
      checkTick(m, t);
    end
    enable = 1'b0;
    @(negedge clk);
    checkIdle("R8 after stop");
  endtask

  initial begin
    int frameLen;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");
    for (int m = 0; m < 4; m++) begin
      frameLen = H_TOTAL_PIX * cppOf(m) * (ACT_LINES + BLANK_LINES);
      runMode(m, 2 * frameLen + 7, -1);
    end
    // R8: stop mid-frame, restart at once from line 0 tick 0
    runMode(1, 50, -1);
    runMode(1, 130, -1);
    // R7: modeSel changed while running has no effect
    runMode(2, 340, 20);
    runMode(0, 120, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    finished = 1;
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule